// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven master for the two-wire management bus used to reach Ethernet PHY registers. It generates the management clock (MDC) from the system clock through a programmable odd divider and shifts out complete management frames on a single data line (MDIO). The data line is split into an output value, an output enable and an input, so a pad or a tristate buffer outside the block can join them. Both framing styles share one register set: short-form frames, where a 5-bit register number follows the port address, and extended frames, where a separate address frame sets a 16-bit register address inside a 5-bit device.

Software writes the configuration word to choose the framing style, the divider and whether the 32-bit preamble is sent. It then starts a frame with a single register write and polls the busy flag. Writing the data word sends a write frame. Writing the control word with its read flag set sends a read frame. In extended mode, writing the address word sends an address frame. A completed read leaves the captured 16 bits in the data word. If no PHY pulled the line low during the second turnaround bit, a sticky read-error flag is raised.

The register interface has single-cycle writes and combinational reads, addressed by word index. Configuration sits at word 12, control at word 13, data at word 14 and address at word 15. All other words read as zero.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, the configuration word (word 12) reads 0x0000_0280. This is divider 5 in bits 15:7, short-form framing (bit 6 = 0), preamble enabled (bit 5 = 0), no read error (bit 1) and not busy (bit 0). The control (word 13), data (word 14) and address (word 15) words read zero.
- R2: While a frame runs, MDC is low for div+1 clocks and then high for div clocks, so one bit lasts 2*div+1 clocks. Busy stays high for exactly N*(2*div+1) clocks after the accepted write, where N is 64 with preamble and 32 without. MDC is low whenever the block is idle.
- R3: A divider value below 5 written to bits 15:7 is stored and read back as 5. Values from 5 to 511 are stored as written.
- R4: Frames are sent MSB first. The preamble is 32 ones unless bit 5 is set. Then come start, opcode, port (5 bits), device or register (5 bits), turnaround (2 bits) and 16 data bits. Short form uses start 01, write opcode 01 and read opcode 10. Extended form uses start 00, address opcode 00, write opcode 01 and read opcode 11. Write and address frames send turnaround 10.
- R5: Writing the data word starts a write frame carrying bits 15:0. Writing the control word with bit 15 set starts a read frame that uses the port (bits 9:5) and device (bits 4:0) from that same write. Writing the address word starts an address frame carrying bits 15:0 in extended mode only; in short-form mode the write just stores the value.
- R6: Busy (configuration bit 0) reads 1 from the clock edge that accepts a frame-starting write until the frame ends. Writes to any register while busy is high change nothing and start no frame.
- R7: The MDIO output changes only on the clock edge that drops MDC. The output enable is low while idle. During a read frame it is low from the first turnaround bit through the last data bit, and it is high for every other bit of a frame.
- R8: A read samples MDIO on the clock edge that raises MDC for each of the 16 data bits. When the frame completes, the data word bits 15:0 return those bits, first-sampled bit in bit 15.
- R9: If MDIO is high when sampled during the second turnaround bit of a read, configuration bit 1 is set when the frame completes (with a pulled-up line the data reads 0xFFFF). The flag is cleared when the next read frame starts.
- R10: A control word write with bit 15 clear only updates the stored port and device and starts no frame; bit 15 reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr`, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable, high when the block drives the line |
| mdio_i | input | 1 | MDIO line value as seen at the pad |

## Verification
The bench uses the default parameters (9-bit divider field, lower bound 5, reset value 5). It programs divider values 5 and 6 at run time, so frames take 11 or 13 clocks per bit; this keeps every frame under a thousand cycles while still covering the lowest legal divide ratio and an even divider value. Writes of 2 and 511 reach both ends of the clamp. A PHY model drives the turnaround low and returns data, or stays silent so the pull-up produces the read-error case. Frames are run in both framing styles, with and without preamble.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    // Register word indices; the bus decodes these.
    localparam int          REG_AW   = 4;
    localparam logic [3:0]  OFS_CFG  = 4'd12;
    localparam logic [3:0]  OFS_CTL  = 4'd13;
    localparam logic [3:0]  OFS_DATA = 4'd14;
    localparam logic [3:0]  OFS_ADDR = 4'd15;

    // Configuration word fields
    localparam int CFG_BUSY_BIT = 0;
    localparam int CFG_RERR_BIT = 1;
    localparam int CFG_NOPRE_BIT = 5;
    localparam int CFG_EXT_BIT  = 6;
    localparam int CFG_DIV_LSB  = 7;

    // Control word fields
    localparam int CTL_DEV_LSB  = 0;
    localparam int CTL_PORT_LSB = 5;
    localparam int CTL_RD_BIT   = 15;

    // Frame geometry
    localparam int FIELD_W   = 5;
    localparam int PAYLOAD_W = 16;
    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = 32;
    localparam int TA0_POS   = 14;
    localparam int TA1_POS   = 15;
    localparam int DATA_POS  = 16;

    typedef enum logic [1:0] {
        FK_ADDR  = 2'd0,
        FK_WRITE = 2'd1,
        FK_READ  = 2'd2
    } frame_kind_e;

    typedef struct packed {
        frame_kind_e            kind;
        logic                   ext;
        logic                   no_pre;
        logic [FIELD_W-1:0]     port;
        logic [FIELD_W-1:0]     dev;
        logic [PAYLOAD_W-1:0]   payload;
    } frame_req_t;

    function automatic logic [1:0] start_code(input logic ext);
        return ext ? 2'b00 : 2'b01;
    endfunction

    function automatic logic [1:0] op_code(input frame_kind_e kind, input logic ext);
        logic [1:0] op;
        case (kind)
            FK_ADDR:  op = 2'b00;
            FK_WRITE: op = 2'b01;
            default:  op = ext ? 2'b11 : 2'b10;
        endcase
        return op;
    endfunction

    // 32 frame bits after the preamble, first bit sent in bit 31.
    function automatic logic [FRAME_LEN-1:0] frame_bits(input frame_req_t r);
        logic [1:0]           ta;
        logic [PAYLOAD_W-1:0] pl;
        ta = (r.kind == FK_READ) ? 2'b11 : 2'b10;
        pl = (r.kind == FK_READ) ? '1 : r.payload;
        return {start_code(r.ext), op_code(r.kind, r.ext), r.port, r.dev, ta, pl};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_pt;
    logic [CNT_W-1:0] full_pt;

    assign half_pt  = {1'b0, div};
    assign full_pt  = {div, 1'b0};
    assign rise_stb = run && (cnt_q == half_pt);
    assign fall_stb = run && (cnt_q == full_pt);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (fall_stb) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (rise_stb)
                mdc <= 1'b1;
        end
    end
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  frame_req_t           req,
    input  logic                 rise_stb,
    input  logic                 fall_stb,
    input  logic                 mdio_i,
    output logic                 busy,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic                 rd_done,
    output logic [PAYLOAD_W-1:0] rd_data,
    output logic                 ta_bad
);
    localparam int SH_W  = PRE_LEN + FRAME_LEN;
    localparam int BIT_W = $clog2(SH_W);
    localparam int FI_W  = $clog2(FRAME_LEN);

    logic                 busy_q;
    logic [SH_W-1:0]      sh_q;
    logic [BIT_W-1:0]     bit_q;
    logic                 rd_q;
    logic                 nopre_q;
    logic [PAYLOAD_W-1:0] cap_q;
    logic                 ta_bad_q;

    logic             in_frame;
    logic [FI_W-1:0]  fidx;
    logic             last_bit;
    logic             released;
    logic [FRAME_LEN-1:0] fbits;

    assign fbits    = frame_bits(req);
    assign in_frame = nopre_q | bit_q[BIT_W-1];
    assign fidx     = bit_q[FI_W-1:0];
    assign last_bit = nopre_q ? (bit_q == BIT_W'(FRAME_LEN - 1)) : (bit_q == BIT_W'(SH_W - 1));
    assign released = rd_q && in_frame && (fidx >= FI_W'(TA0_POS));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            sh_q     <= '0;
            bit_q    <= '0;
            rd_q     <= 1'b0;
            nopre_q  <= 1'b0;
            cap_q    <= '0;
            ta_bad_q <= 1'b0;
        end else if (start && !busy_q) begin
            busy_q   <= 1'b1;
            bit_q    <= '0;
            sh_q     <= req.no_pre ? {fbits, {PRE_LEN{1'b0}}} : {{PRE_LEN{1'b1}}, fbits};
            rd_q     <= (req.kind == FK_READ);
            nopre_q  <= req.no_pre;
            cap_q    <= '0;
            ta_bad_q <= 1'b0;
        end else if (busy_q) begin
            if (rise_stb && rd_q && in_frame) begin
                if (fidx == FI_W'(TA1_POS))
                    ta_bad_q <= mdio_i;
                if (fidx >= FI_W'(DATA_POS))
                    cap_q <= {cap_q[PAYLOAD_W-2:0], mdio_i};
            end
            if (fall_stb) begin
                if (last_bit) begin
                    busy_q <= 1'b0;
                end else begin
                    bit_q <= bit_q + 1'b1;
                    sh_q  <= {sh_q[SH_W-2:0], 1'b0};
                end
            end
        end
    end

    assign busy    = busy_q;
    assign mdio_o  = busy_q & sh_q[SH_W-1];
    assign mdio_oe = busy_q & ~released;
    assign rd_done = busy_q & fall_stb & last_bit & rd_q;
    assign rd_data = cap_q;
    assign ta_bad  = ta_bad_q;
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int DIV_W     = 9,
    parameter int DIV_MIN   = 5,
    parameter int DIV_RESET = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wen,
    input  logic [REG_AW-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 busy,
    input  logic                 rd_done,
    input  logic [PAYLOAD_W-1:0] rd_data,
    input  logic                 ta_bad,
    output logic                 start,
    output frame_req_t           req,
    output logic [DIV_W-1:0]     div
);
    localparam logic [DIV_W-1:0] DIV_LO  = DIV_W'(DIV_MIN);
    localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(DIV_RESET);

    logic                 ext_q;
    logic                 nopre_q;
    logic                 rerr_q;
    logic [DIV_W-1:0]     div_q;
    logic [FIELD_W-1:0]   port_q;
    logic [FIELD_W-1:0]   dev_q;
    logic [PAYLOAD_W-1:0] data_q;
    logic [PAYLOAD_W-1:0] addr_q;

    logic                 acc;
    logic                 go_rd, go_wr, go_ad;
    logic [DIV_W-1:0]     div_in;
    logic                 unused_hi;

    assign unused_hi = ^bus_wdata[31:16];
    assign acc    = bus_wen && !busy;
    assign go_rd  = acc && (bus_addr == OFS_CTL) && bus_wdata[CTL_RD_BIT];
    assign go_wr  = acc && (bus_addr == OFS_DATA);
    assign go_ad  = acc && (bus_addr == OFS_ADDR) && ext_q;
    assign start  = go_rd | go_wr | go_ad;
    assign div_in = bus_wdata[CFG_DIV_LSB +: DIV_W];
    assign div    = div_q;

    always_comb begin
        req.ext     = ext_q;
        req.no_pre  = nopre_q;
        req.payload = bus_wdata[PAYLOAD_W-1:0];
        if (go_rd) begin
            req.kind = FK_READ;
            req.port = bus_wdata[CTL_PORT_LSB +: FIELD_W];
            req.dev  = bus_wdata[CTL_DEV_LSB +: FIELD_W];
        end else begin
            req.kind = go_wr ? FK_WRITE : FK_ADDR;
            req.port = port_q;
            req.dev  = dev_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q   <= 1'b0;
            nopre_q <= 1'b0;
            rerr_q  <= 1'b0;
            div_q   <= DIV_RST;
            port_q  <= '0;
            dev_q   <= '0;
            data_q  <= '0;
            addr_q  <= '0;
        end else begin
            if (acc) begin
                case (bus_addr)
                    OFS_CFG: begin
                        ext_q   <= bus_wdata[CFG_EXT_BIT];
                        nopre_q <= bus_wdata[CFG_NOPRE_BIT];
                        div_q   <= (div_in < DIV_LO) ? DIV_LO : div_in;
                    end
                    OFS_CTL: begin
                        port_q <= bus_wdata[CTL_PORT_LSB +: FIELD_W];
                        dev_q  <= bus_wdata[CTL_DEV_LSB +: FIELD_W];
                    end
                    OFS_DATA: data_q <= bus_wdata[PAYLOAD_W-1:0];
                    OFS_ADDR: addr_q <= bus_wdata[PAYLOAD_W-1:0];
                    default: ;
                endcase
            end
            if (rd_done) begin
                data_q <= rd_data;
                rerr_q <= ta_bad;
            end else if (go_rd) begin
                rerr_q <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CFG: begin
                bus_rdata[CFG_BUSY_BIT]              = busy;
                bus_rdata[CFG_RERR_BIT]              = rerr_q;
                bus_rdata[CFG_NOPRE_BIT]             = nopre_q;
                bus_rdata[CFG_EXT_BIT]               = ext_q;
                bus_rdata[CFG_DIV_LSB +: DIV_W]      = div_q;
            end
            OFS_CTL: begin
                bus_rdata[CTL_PORT_LSB +: FIELD_W]   = port_q;
                bus_rdata[CTL_DEV_LSB +: FIELD_W]    = dev_q;
            end
            OFS_DATA: bus_rdata[PAYLOAD_W-1:0] = data_q;
            OFS_ADDR: bus_rdata[PAYLOAD_W-1:0] = addr_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int DIV_W     = 9,
    parameter int DIV_MIN   = 5,
    parameter int DIV_RESET = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wen,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic                 busy_w;
    logic                 start_w;
    frame_req_t           req_w;
    logic [DIV_W-1:0]     div_w;
    logic                 rise_w, fall_w;
    logic                 rd_done_w;
    logic [PAYLOAD_W-1:0] rd_data_w;
    logic                 ta_bad_w;

    mdio_regs #(
        .DIV_W     (DIV_W),
        .DIV_MIN   (DIV_MIN),
        .DIV_RESET (DIV_RESET)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wen   (bus_wen),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy_w),
        .rd_done   (rd_done_w),
        .rd_data   (rd_data_w),
        .ta_bad    (ta_bad_w),
        .start     (start_w),
        .req       (req_w),
        .div       (div_w)
    );

    mdio_clkgen #(
        .DIV_W (DIV_W)
    ) u_clk (
        .clk      (clk),
        .rst      (rst),
        .run      (busy_w),
        .div      (div_w),
        .mdc      (mdc),
        .rise_stb (rise_w),
        .fall_stb (fall_w)
    );

    mdio_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start_w),
        .req      (req_w),
        .rise_stb (rise_w),
        .fall_stb (fall_w),
        .mdio_i   (mdio_i),
        .busy     (busy_w),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_done  (rd_done_w),
        .rd_data  (rd_data_w),
        .ta_bad   (ta_bad_w)
    );
endmodule

// File: rtl/mdio_mgmt_master_checks.sv
module mdio_mgmt_master_checks #(
    parameter int DIV_W   = 9,
    parameter int DIV_MIN = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             start,
    input logic [DIV_W-1:0] div,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic [31:0]      cfg_word,
    input logic [3:0]       bus_addr
);
    // R2: no clock activity while idle
    assert_mdc_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    // R3: stored divider never below the lower bound
    assert_div_floor_R3: assert property (@(posedge clk) disable iff (rst)
        div >= DIV_W'(DIV_MIN));

    // R6: an accepted start raises busy on the next edge
    assert_start_sets_busy_R6: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R6: configuration is frozen while a frame runs
    assert_div_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(div));

    // R7: line released while idle
    assert_oe_idle_low_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe);

    // R7: output value only moves when MDC falls
    assert_out_stable_high_R7: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> $stable(mdio_o));

    // R9: read error only rises as a frame ends
    assert_rerr_at_end_R9: assert property (@(posedge clk) disable iff (rst)
        ((bus_addr == 4'd12) && $past(bus_addr == 4'd12) && $rose(cfg_word[1])) |-> $fell(busy));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_checks #(
    .DIV_W   (DIV_W),
    .DIV_MIN (DIV_MIN)
) u_checks (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy_w),
    .start    (start_w),
    .div      (div_w),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .cfg_word (bus_rdata),
    .bus_addr (bus_addr)
);

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb;

    localparam logic [3:0] A_CFG  = 4'd12;
    localparam logic [3:0] A_CTL  = 4'd13;
    localparam logic [3:0] A_DATA = 4'd14;
    localparam logic [3:0] A_ADDR = 4'd15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wen = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        phy_oe = 1'b0;
    logic        phy_bit = 1'b1;
    logic        mdio_line;

    assign mdio_line = mdio_oe ? mdio_o : (phy_oe ? phy_bit : 1'b1);

    always #4 clk = ~clk;

    mdio_mgmt_master u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wen   (bus_wen),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_line)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    typedef struct {
        logic [63:0] line;
        logic [63:0] oe;
        int          len;
    } exp_frame_t;

    exp_frame_t exp_q[$];

    // PHY model state, set by the driver before each frame
    int          rc = 0;
    bit          cur_rd = 0;
    bit          cur_phy = 0;
    int          cur_pre = 32;
    logic [15:0] cur_val = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wen   = 1'b1;
        @(negedge clk);
        bus_wen   = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Expected line and enable per bit (bit k at index k), from R4/R7/R9
    function automatic exp_frame_t build(input bit ext, input int kind, input logic [4:0] port,
                                         input logic [4:0] dev, input logic [15:0] pl,
                                         input bit nopre, input bit phy, input logic [15:0] pv);
        exp_frame_t  e;
        logic [31:0] fr;
        logic [1:0]  st, op;
        int          pre;
        st  = ext ? 2'b00 : 2'b01;
        op  = (kind == 0) ? 2'b00 : (kind == 1) ? 2'b01 : (ext ? 2'b11 : 2'b10);
        fr  = {st, op, port, dev, 2'b10, pl};
        pre = nopre ? 0 : 32;
        e.len  = pre + 32;
        e.line = '1;
        e.oe   = '1;
        for (int k = 0; k < 32; k++) begin
            e.line[pre + k] = fr[31 - k];
            if (kind == 2 && k >= 14) begin
                e.oe[pre + k] = 1'b0;
                if (k == 14)      e.line[pre + k] = 1'b1;
                else if (k == 15) e.line[pre + k] = phy ? 1'b0 : 1'b1;
                else              e.line[pre + k] = phy ? pv[31 - k] : 1'b1;
            end
        end
        return e;
    endfunction

    // Scoreboard monitor: pops one expected frame and compares sampled bits
    initial begin
        forever begin
            exp_frame_t  e;
            logic [63:0] gl, go;
            wait (exp_q.size() > 0);
            e  = exp_q[0];
            gl = '1;
            go = '1;
            for (int k = 0; k < e.len; k++) begin
                @(posedge mdc);
                gl[k] = mdio_line;
                go[k] = mdio_oe;
                rc++;
            end
            checks++;
            if (gl !== e.line) begin
                fails++;
                $display("FAIL R4 frame bits actual=0x%016h expected=0x%016h", gl, e.line);
            end
            checks++;
            if (go !== e.oe) begin
                fails++;
                $display("FAIL R7 output enable actual=0x%016h expected=0x%016h", go, e.oe);
            end
            void'(exp_q.pop_front());
        end
    end

    // PHY model: drives turnaround low and data after MDC falls
    initial begin
        forever begin
            int f;
            @(negedge mdc);
            f = rc - cur_pre;
            if (cur_rd && cur_phy && f == 15) begin
                phy_oe = 1'b1; phy_bit = 1'b0;
            end else if (cur_rd && cur_phy && f >= 16 && f <= 31) begin
                phy_oe = 1'b1; phy_bit = cur_val[31 - f];
            end else begin
                phy_oe = 1'b0; phy_bit = 1'b1;
            end
        end
    end

    task automatic run_frame(input logic [3:0] a, input logic [31:0] d,
                             input bit ext, input int kind, input logic [4:0] port,
                             input logic [4:0] dev, input logic [15:0] pl, input bit nopre,
                             input bit phy, input logic [15:0] pv, input int div,
                             input bit wait_end, output logic [31:0] first_stat);
        exp_frame_t e;
        int cnt;
        e = build(ext, kind, port, dev, pl, nopre, phy, pv);
        rc      = 0;
        cur_rd  = (kind == 2);
        cur_phy = phy;
        cur_val = pv;
        cur_pre = nopre ? 0 : 32;
        exp_q.push_back(e);
        wr(a, d);
        bus_addr = A_CFG;
        #1;
        first_stat = bus_rdata;
        if (wait_end) begin
            cnt = 0;
            while (bus_rdata[0] === 1'b1) begin
                cnt++;
                @(negedge clk);
                #1;
            end
            chk("R2 busy length", cnt, e.len * (2 * div + 1));
            wait (exp_q.size() == 0);
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            fails++;
            $display("FAIL R6 watchdog actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, st;
        int idle_bad;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_CFG, v);  chk("R1 cfg reset", v, 32'h0000_0280);
        rd(A_CTL, v);  chk("R1 ctl reset", v, 32'h0);
        rd(A_DATA, v); chk("R1 data reset", v, 32'h0);
        rd(A_ADDR, v); chk("R1 addr reset", v, 32'h0);

        // R3 divider clamp
        wr(A_CFG, 32'd2 << 7);   rd(A_CFG, v); chk("R3 clamp low", v, 32'h0000_0280);
        wr(A_CFG, 32'd511 << 7); rd(A_CFG, v); chk("R3 max value", v, 32'h0000_FF80);
        wr(A_CFG, 32'h0000_0280);

        // R10 control write without read flag
        wr(A_CTL, 32'h0000_0069);
        repeat (3) @(negedge clk);
        rd(A_CFG, v);  chk("R10 no frame busy", v, 32'h0000_0280);
        rd(A_CTL, v);  chk("R10 ctl stored", v, 32'h0000_0069);

        // R5 address write in short-form mode only stores
        wr(A_ADDR, 32'h0000_ABCD);
        idle_bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mdc !== 1'b0) idle_bad++;
        end
        chk("R5 short-form addr no clock", idle_bad, 0);
        rd(A_ADDR, v); chk("R5 addr stored", v, 32'h0000_ABCD);
        rd(A_CFG, v);  chk("R5 addr no busy", v, 32'h0000_0280);

        // R4 R5 R6 short-form write, port 3 reg 9
        run_frame(A_DATA, 32'h1234, 0, 1, 5'd3, 5'd9, 16'h1234, 0, 0, 16'h0, 5, 1, st);
        chk("R6 busy at first cycle", st & 32'h1, 32'h1);

        // R8 short-form read with PHY present, port 5 reg 2
        run_frame(A_CTL, 32'h80A2, 0, 2, 5'd5, 5'd2, 16'h0, 0, 1, 16'hA5C3, 5, 1, st);
        rd(A_DATA, v); chk("R8 read data", v, 32'h0000_A5C3);
        rd(A_CFG, v);  chk("R9 no error with PHY", v & 32'h2, 32'h0);

        // R9 no PHY: error flag and all ones
        run_frame(A_CTL, 32'h80A2, 0, 2, 5'd5, 5'd2, 16'h0, 0, 0, 16'h0, 5, 1, st);
        rd(A_DATA, v); chk("R9 pulled-up data", v, 32'h0000_FFFF);
        rd(A_CFG, v);  chk("R9 error set", v & 32'h2, 32'h2);

        // R9 flag cleared when the next read starts
        run_frame(A_CTL, 32'h80A2, 0, 2, 5'd5, 5'd2, 16'h0, 0, 1, 16'h3C5A, 5, 1, st);
        chk("R9 cleared at read start", st & 32'h3, 32'h1);
        rd(A_DATA, v); chk("R8 second read", v, 32'h0000_3C5A);

        // Extended framing, no preamble, divider 6
        wr(A_CFG, 32'h0000_0360);
        wr(A_CTL, 32'h0000_00E1);
        run_frame(A_ADDR, 32'h0C0D, 1, 0, 5'd7, 5'd1, 16'h0C0D, 1, 0, 16'h0, 6, 1, st);
        run_frame(A_DATA, 32'h5A5A, 1, 1, 5'd7, 5'd1, 16'h5A5A, 1, 0, 16'h0, 6, 1, st);
        run_frame(A_CTL, 32'h80E1, 1, 2, 5'd7, 5'd1, 16'h0, 1, 1, 16'h0F0F, 6, 1, st);
        rd(A_DATA, v); chk("R8 extended read", v, 32'h0000_0F0F);

        // Extended address frame with preamble, divider 5
        wr(A_CFG, 32'h0000_02C0);
        run_frame(A_ADDR, 32'h0001, 1, 0, 5'd7, 5'd1, 16'h0001, 0, 0, 16'h0, 5, 1, st);

        // R6 writes during a frame are ignored
        wr(A_CFG, 32'h0000_0280);
        run_frame(A_DATA, 32'h1234, 0, 1, 5'd7, 5'd1, 16'h1234, 0, 0, 16'h0, 5, 0, st);
        wr(A_DATA, 32'hBEEF);
        wr(A_CTL,  32'h80FF);
        wr(A_CFG,  32'h0000_03E0);
        wr(A_ADDR, 32'h7777);
        wait (exp_q.size() == 0);
        do rd(A_CFG, v); while (v[0] === 1'b1);
        chk("R6 cfg unchanged", v, 32'h0000_0280);
        rd(A_DATA, v); chk("R6 data unchanged", v, 32'h0000_1234);
        rd(A_CTL, v);  chk("R6 ctl unchanged", v, 32'h0000_00E1);
        rd(A_ADDR, v); chk("R6 addr unchanged", v, 32'h0000_0001);
        idle_bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (mdc !== 1'b0 || mdio_oe !== 1'b0) idle_bad++;
        end
        chk("R7 idle after ignored writes", idle_bad, 0);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule